// File: doc/BRIEF.md
# ADC Watchdog Interrupt Unit

This unit sits next to an analog-to-digital converter and sees every finished conversion as a one-cycle strobe with a channel number and a 10-bit result. Two channels, chosen by parameter, are guarded. Each guarded channel has its own low and high threshold. A result is out of range when it is strictly below the low threshold or strictly above the high threshold. Each of the four threshold checks has its own sticky status bit in a compare result register. Any such hit raises the watchdog pending flag. Every conversion raises the end-of-conversion pending flag.

Software reaches the unit over a small register bus. Reads are combinational and writes are single-cycle. Through the bus, software programs the thresholds, the two enables and the base of a vector register, and it clears or sets the pending flags. One interrupt line goes to the CPU. The vector register gives a service routine address: its bit 1 picks the watchdog entry over the end-of-conversion entry whenever a watchdog request is active.

Top module: `adc_guard_irq`

## Requirements
- R1: After reset the control register reads 0 (both flags and both enables clear) and the compare result register reads 0. Both low thresholds read 0, both high thresholds read 0x3FF, the vector reads 0x02 and `irq` is low.
- R2: A `conv_done` strobe sets the end-of-conversion pending flag (control bit 7), which is visible from the next cycle.
- R3: For a guarded channel, a result below its low threshold sets that channel's low status bit, and a result above its high threshold sets its high status bit. A result equal to either threshold sets neither bit. Compare result bit order: bit 0 = guard 0 low, bit 1 = guard 0 high, bit 2 = guard 1 low, bit 3 = guard 1 high.
- R4: A conversion on a channel that is not guarded sets no compare result bit and does not set the watchdog flag.
- R5: Any compare result bit that becomes set also sets the watchdog pending flag (control bit 6).
- R6: Pending flags and compare result bits are sticky. They stay set through idle cycles and through later in-range conversions until software writes the control register.
- R7: A control write with bit 6 at 0 clears the watchdog flag and all compare result bits.
- R8: A control write with bit 6 or bit 7 at 1 sets that pending flag, exactly as a hardware event would.
- R9: `irq` is high exactly when the watchdog flag and its enable (control bit 1) are both set, or the end-of-conversion flag and its enable (control bit 0) are both set.
- R10: The vector reads {base[7:2], s, 0}, where s = 0 while the watchdog flag and its enable are both set, and s = 1 otherwise. The watchdog therefore takes priority over a pending end of conversion.
- R11: When a hardware event and a software clear hit the same flag in the same cycle, the flag ends up set. The compare result register then keeps its old bits and also gains the new ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_done | input | 1 | One-cycle strobe: conversion finished |
| conv_ch | input | CH_W | Channel of the finished conversion |
| conv_res | input | RES_W | Conversion result |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address (0 ctrl, 1 compare result, 2/3 guard 0 low/high, 4/5 guard 1 low/high, 6 vector base, 7 vector) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, zero-extended |
| irq | output | 1 | Interrupt request to the CPU |

## Verification
The bench aims at the exact threshold edges. A comparator written with `<=` in place of `<` would flag a result equal to a threshold as out of range. It also places a hardware watchdog hit in the same cycle as a software clear. A design that let the clear win would drop that event and lose its status bits. The bench checks that the status bits survive in-range conversions and clear only through the flag. It also checks the vector priority with both flags pending, where an inverted source bit would send the CPU to the end-of-conversion routine.

// File: rtl/adcg_pkg.sv
package adcg_pkg;
   localparam int ADDR_W = 3;
   localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
   localparam logic [ADDR_W-1:0] A_CRR   = 3'd1;
   localparam logic [ADDR_W-1:0] A_LO0   = 3'd2;
   localparam logic [ADDR_W-1:0] A_HI0   = 3'd3;
   localparam logic [ADDR_W-1:0] A_LO1   = 3'd4;
   localparam logic [ADDR_W-1:0] A_HI1   = 3'd5;
   localparam logic [ADDR_W-1:0] A_VBASE = 3'd6;
   localparam logic [ADDR_W-1:0] A_VEC   = 3'd7;
   // control register bit positions
   localparam int B_EOC_EN = 0;
   localparam int B_WD_EN  = 1;
   localparam int B_WD_P   = 6;
   localparam int B_EOC_P  = 7;
   localparam int NGUARD   = 2;
   localparam int NCHK     = 2 * NGUARD;
endpackage

// File: rtl/adcg_window.sv
module adcg_window #(
   parameter int RES_W = 10,
   parameter int CH_W  = 4,
   parameter logic [CH_W-1:0] GUARD_CH = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             conv_done,
   input  logic [CH_W-1:0]  conv_ch,
   input  logic [RES_W-1:0] conv_res,
   input  logic [RES_W-1:0] lo_thr,
   input  logic [RES_W-1:0] hi_thr,
   output logic             hit_lo,
   output logic             hit_hi
);
   logic mine;
   assign mine   = conv_done && (conv_ch == GUARD_CH);
   assign hit_lo = mine && (conv_res < lo_thr);
   assign hit_hi = mine && (conv_res > hi_thr);

   // R3: equality with a threshold is in range
   p_eq_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_done && conv_res == lo_thr) |-> !hit_lo);
   // R4: other channels never hit
   p_other_ch_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_ch != GUARD_CH) |-> !(hit_lo || hit_hi));
endmodule

// File: rtl/adcg_pending.sv
module adcg_pending
   import adcg_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            hw_eoc,
   input  logic [NCHK-1:0] hw_hits,
   input  logic            sw_wr,
   input  logic            sw_eoc,
   input  logic            sw_wd,
   output logic            eoc_q,
   output logic            wd_q,
   output logic [NCHK-1:0] crr_q
);
   logic hw_wd, sw_clr_wd;
   assign hw_wd     = |hw_hits;
   assign sw_clr_wd = sw_wr && !sw_wd && !hw_wd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eoc_q <= 1'b0;
         wd_q  <= 1'b0;
         crr_q <= '0;
      end else begin
         eoc_q <= hw_eoc | (sw_wr ? sw_eoc : eoc_q);
         wd_q  <= hw_wd  | (sw_wr ? sw_wd  : wd_q);
         crr_q <= sw_clr_wd ? '0 : (crr_q | hw_hits);
      end
   end

   // R2: a conversion always leaves end of conversion pending
   p_eoc_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      hw_eoc |=> eoc_q);
   // R5: status bits never stand without the watchdog flag
   p_crr_needs_wd_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (crr_q != '0) |-> wd_q);
   // R6: flags are sticky without a software write
   p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wd_q && !sw_wr) |=> wd_q);
   // R7: status bits drop together with the watchdog flag
   p_crr_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wd_q) |-> (crr_q == '0));
   // R11: a hardware hit beats a software clear
   p_hw_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      hw_wd |=> wd_q);
endmodule

// File: rtl/adc_guard_irq.sv
module adc_guard_irq
   import adcg_pkg::*;
#(
   parameter int RES_W  = 10,
   parameter int CH_W   = 4,
   parameter int DATA_W = 16,
   parameter int VEC_W  = 8,
   parameter logic [CH_W-1:0] GUARD_CH0 = 4'd2,
   parameter logic [CH_W-1:0] GUARD_CH1 = 4'd5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              conv_done,
   input  logic [CH_W-1:0]   conv_ch,
   input  logic [RES_W-1:0]  conv_res,
   input  logic              bus_we,
   input  logic [2:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);
   localparam int BASE_W = VEC_W - 2;
   localparam logic [RES_W-1:0] THR_MAX = {RES_W{1'b1}};

   if (DATA_W < RES_W || DATA_W < VEC_W || DATA_W < 8) begin : g_bad_width
      $error("adc_guard_irq: DATA_W too narrow");
   end
   if (VEC_W < 3) begin : g_bad_vec
      $error("adc_guard_irq: VEC_W must be at least 3");
   end
   if (GUARD_CH0 == GUARD_CH1) begin : g_bad_guard
      $error("adc_guard_irq: guarded channels must differ");
   end

   logic [RES_W-1:0]  lo_q [NGUARD];
   logic [RES_W-1:0]  hi_q [NGUARD];
   logic [BASE_W-1:0] base_q;
   logic              eoc_en_q, wd_en_q;
   logic [NCHK-1:0]   hits;
   logic              eoc_p, wd_p, wd_req, eoc_req, sw_wr;
   logic [NCHK-1:0]   crr;
   logic [VEC_W-1:0]  vec;

   for (genvar g = 0; g < NGUARD; g++) begin : g_guard
      localparam logic [CH_W-1:0] GCH = (g == 0) ? GUARD_CH0 : GUARD_CH1;
      adcg_window #(.RES_W(RES_W), .CH_W(CH_W), .GUARD_CH(GCH)) u_win (
         .clk      (clk),
         .rst_n    (rst_n),
         .conv_done(conv_done),
         .conv_ch  (conv_ch),
         .conv_res (conv_res),
         .lo_thr   (lo_q[g]),
         .hi_thr   (hi_q[g]),
         .hit_lo   (hits[2*g]),
         .hit_hi   (hits[2*g+1])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lo_q[g] <= '0;
            hi_q[g] <= THR_MAX;
         end else if (bus_we) begin
            if (bus_addr == A_LO0 + 3'(2*g)) lo_q[g] <= bus_wdata[RES_W-1:0];
            if (bus_addr == A_HI0 + 3'(2*g)) hi_q[g] <= bus_wdata[RES_W-1:0];
         end
      end
   end

   assign sw_wr = bus_we && (bus_addr == A_CTRL);

   adcg_pending u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .hw_eoc (conv_done),
      .hw_hits(hits),
      .sw_wr  (sw_wr),
      .sw_eoc (bus_wdata[B_EOC_P]),
      .sw_wd  (bus_wdata[B_WD_P]),
      .eoc_q  (eoc_p),
      .wd_q   (wd_p),
      .crr_q  (crr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eoc_en_q <= 1'b0;
         wd_en_q  <= 1'b0;
         base_q   <= '0;
      end else if (bus_we) begin
         if (bus_addr == A_CTRL) begin
            eoc_en_q <= bus_wdata[B_EOC_EN];
            wd_en_q  <= bus_wdata[B_WD_EN];
         end
         if (bus_addr == A_VBASE) base_q <= bus_wdata[VEC_W-1:2];
      end
   end

   assign wd_req  = wd_p && wd_en_q;
   assign eoc_req = eoc_p && eoc_en_q;
   assign irq     = wd_req || eoc_req;
   assign vec     = {base_q, ~wd_req, 1'b0};

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_CTRL: begin
            bus_rdata[B_EOC_P]  = eoc_p;
            bus_rdata[B_WD_P]   = wd_p;
            bus_rdata[B_WD_EN]  = wd_en_q;
            bus_rdata[B_EOC_EN] = eoc_en_q;
         end
         A_CRR:   bus_rdata[NCHK-1:0]  = crr;
         A_LO0:   bus_rdata[RES_W-1:0] = lo_q[0];
         A_HI0:   bus_rdata[RES_W-1:0] = hi_q[0];
         A_LO1:   bus_rdata[RES_W-1:0] = lo_q[1];
         A_HI1:   bus_rdata[RES_W-1:0] = hi_q[1];
         A_VBASE: bus_rdata[VEC_W-1:2] = base_q;
         default: bus_rdata[VEC_W-1:0] = vec;
      endcase
   end

   // R10: an active watchdog request owns the vector
   p_vec_priority_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wd_p && wd_en_q) |-> (vec[1] == 1'b0 && vec[0] == 1'b0));
   // R9: no interrupt without an enabled pending flag
   p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ((wd_p && wd_en_q) || (eoc_p && eoc_en_q)));
endmodule

// File: tb/adc_guard_irq_tb.sv
`timescale 1ns/1ps
module adc_guard_irq_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        conv_done = 1'b0;
   logic [3:0]  conv_ch = '0;
   logic [9:0]  conv_res = '0;
   logic        bus_we = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        irq;
   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   adc_guard_irq u_dut (
      .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_ch(conv_ch),
      .conv_res(conv_res), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   // {channel, result, expected compare result bits}
   localparam logic [17:0] TV [9] = '{
      {4'd2, 10'd99,   4'b0001},
      {4'd2, 10'd100,  4'b0000},
      {4'd2, 10'd200,  4'b0000},
      {4'd2, 10'd201,  4'b0010},
      {4'd5, 10'd299,  4'b0100},
      {4'd5, 10'd901,  4'b1000},
      {4'd5, 10'd900,  4'b0000},
      {4'd3, 10'd0,    4'b0000},
      {4'd7, 10'd1023, 4'b0000}
   };

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] d);
      @(negedge clk);
      bus_addr = a;
      #0.5 d = bus_rdata;
   endtask

   task automatic conv(input logic [3:0] c, input logic [9:0] r);
      @(negedge clk);
      conv_done = 1'b1; conv_ch = c; conv_res = r;
      @(negedge clk);
      conv_done = 1'b0;
   endtask

   task automatic finish_run;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [15:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd(3'd0, d); chk("R1 ctrl", d, 16'h0);
      rd(3'd1, d); chk("R1 crr", d, 16'h0);
      rd(3'd2, d); chk("R1 lo0", d, 16'h0);
      rd(3'd3, d); chk("R1 hi0", d, 16'h3FF);
      rd(3'd4, d); chk("R1 lo1", d, 16'h0);
      rd(3'd5, d); chk("R1 hi1", d, 16'h3FF);
      rd(3'd7, d); chk("R1 vec", d, 16'h02);
      chk("R1 irq", {15'd0, irq}, 16'h0);

      wr(3'd2, 16'd100); wr(3'd3, 16'd200);
      wr(3'd4, 16'd300); wr(3'd5, 16'd900);

      // R2 R3 R4 R5 table walk
      foreach (TV[i]) begin
         wr(3'd0, 16'h0003);
         conv(TV[i][17:14], TV[i][13:4]);
         rd(3'd1, d); chk("R3/R4 crr", d, {12'd0, TV[i][3:0]});
         rd(3'd0, d);
         chk("R2/R5 ctrl", d, (TV[i][3:0] != 0) ? 16'h00C3 : 16'h0083);
         chk("R9 irq eoc", {15'd0, irq}, 16'h1);
      end

      // R6 sticky through idle and in-range conversions
      wr(3'd0, 16'h0003);
      conv(4'd2, 10'd50);
      conv(4'd5, 10'd500);
      repeat (3) @(negedge clk);
      rd(3'd0, d); chk("R6 ctrl", d, 16'h00C3);
      rd(3'd1, d); chk("R6 crr", d, 16'h0001);

      // R11 hardware hit against software clear in one cycle
      @(negedge clk);
      conv_done = 1'b1; conv_ch = 4'd5; conv_res = 10'd950;
      bus_we = 1'b1; bus_addr = 3'd0; bus_wdata = 16'h0003;
      @(negedge clk);
      conv_done = 1'b0; bus_we = 1'b0;
      rd(3'd0, d); chk("R11 ctrl", d, 16'h00C3);
      rd(3'd1, d); chk("R11 crr", d, 16'h0009);

      // R7 software clear empties compare result
      wr(3'd0, 16'h0003);
      rd(3'd0, d); chk("R7 ctrl", d, 16'h0003);
      rd(3'd1, d); chk("R7 crr", d, 16'h0000);

      // R8 R9 software-raised request, enables
      wr(3'd0, 16'h0040);
      chk("R9 irq disabled", {15'd0, irq}, 16'h0);
      rd(3'd0, d); chk("R8 ctrl", d, 16'h0040);
      rd(3'd1, d); chk("R8 crr untouched", d, 16'h0000);
      wr(3'd0, 16'h0042);
      chk("R8 irq wd", {15'd0, irq}, 16'h1);

      // R10 vector source and priority
      wr(3'd6, 16'h00A4);
      rd(3'd7, d); chk("R10 vec wd", d, 16'h00A4);
      wr(3'd0, 16'h0081);
      rd(3'd7, d); chk("R10 vec eoc", d, 16'h00A6);
      chk("R8 irq eoc", {15'd0, irq}, 16'h1);
      wr(3'd0, 16'h00C3);
      rd(3'd7, d); chk("R10 vec both", d, 16'h00A4);
      wr(3'd0, 16'h00C1);
      rd(3'd7, d); chk("R10 vec wd disabled", d, 16'h00A6);
      wr(3'd0, 16'h00C0);
      chk("R9 irq none enabled", {15'd0, irq}, 16'h0);

      finish_run();
   end
endmodule